// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a serially programmed 8-bit digital-to-analog converter. A host drives four slow serial wires: an active-low select, a frame-sync, a serial clock and a data line. All four are oversampled by the fast system clock, and the receiver gathers a 16-bit command word. It then updates either the converter code or the reference-source choice, and it refreshes the speed and power-down mode flags.

A frame opens on a falling frame-sync. Data is taken on each falling serial-clock edge, most significant bit first. The word takes effect on the rising serial-clock edge that follows the 16th bit. A rising frame-sync ends the word early. Bit 15 and bit 12 together form the register select, and that select routes the word. Every committed word raises a strobe for one system clock. The analog stages that consume these outputs sit outside the block.

Top module: `sdac_cmd_rx`

## Requirements
- R1: While the select input is high, serial-clock, frame-sync and data activity causes no strobe and changes no output. Raising the select in the middle of a frame abandons that frame.
- R2: A falling frame-sync with the select low opens a frame. Bits are then captured on falling serial-clock edges, most significant first, into positions 15 down to 0.
- R3: Once 16 bits are in, the word commits on the next rising serial-clock edge, and the outputs and strobe follow a fixed number of system clocks later.
- R4: A rising frame-sync after one to fifteen bits commits the word at once. The received bits keep their high-order positions and every bit not received reads as zero.
- R5: Select value 00 (bit 15 = 0, bit 12 = 0) loads bits 11..4 into the converter code output.
- R6: Select value 11 loads bits 1..0 into the reference select (0 and 3 external, 1 low internal, 2 high internal). Bits 11..2 have no effect.
- R7: Select values 01 and 10 leave both the converter code and the reference select unchanged.
- R8: Every committed word, whatever its select, loads bit 14 into the fast flag (1 = fast) and bit 13 into the power-down flag (1 = powered down).
- R9: Each committed word produces exactly one strobe pulse, one system clock wide.
- R10: Reset drives the code, reference select, both flags and the strobe to zero.
- R11: A frame-sync that rises before any bit has been received commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| csn_i | input | 1 | Active-low device select |
| fs_i | input | 1 | Frame-sync; its falling edge opens a frame and its rising edge ends one |
| sclk_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial data |
| dac_code_o | output | 8 | Converter code latch |
| ref_sel_o | output | 2 | Reference source selection latch |
| fast_o | output | 1 | Fast settling mode flag |
| pwrdn_o | output | 1 | Power-down request flag |
| upd_o | output | 1 | One-cycle strobe for each committed word |

## Verification
The bench uses words with distinct patterns in the payload and the mode bits, so that each select value is seen to change only its own latch. A control word with a dense don't-care payload shows that only the two low bits reach the reference select. The two reserved selects show that the mode flags move while the code and reference hold. Frames cut short at 1, 8 and 12 bits test zero fill and left alignment, and a zero-bit frame tests that nothing commits. Frames sent with the select high, or deselected halfway, must produce no strobe, which separates the select gating from the frame logic. All-zero and all-ones codes cover both ends of the code range.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int WORD_W     = 16;
  localparam int SEL_HI_BIT = 15;
  localparam int SPD_BIT    = 14;
  localparam int PWR_BIT    = 13;
  localparam int SEL_LO_BIT = 12;
  localparam int PAY_MSB    = 11;
  localparam int REF_W      = 2;

  typedef enum logic [1:0] {
    SEL_DAC  = 2'b00,
    SEL_RSV1 = 2'b01,
    SEL_RSV2 = 2'b10,
    SEL_CTL  = 2'b11
  } sel_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int           W      = 4,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else if (g == 0) stg_q[g] <= d_i;
        else stg_q[g] <= stg_q[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdac_frame.sv
module sdac_frame
  import sdac_pkg::*;
#(
  parameter int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              fs_s,
  input  logic              sclk_s,
  input  logic              din_s,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);
  logic              sclk_d, fs_d;
  logic              active_q, active_n;
  logic              full_q, full_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] shreg_q, shreg_n;
  logic              commit_q, commit_n;
  logic [WORD_W-1:0] cword_q, cword_n;
  logic              sclk_fall, sclk_rise, fs_fall, fs_rise;

  assign sclk_fall = sclk_d & ~sclk_s;
  assign sclk_rise = ~sclk_d & sclk_s;
  assign fs_fall   = fs_d & ~fs_s;
  assign fs_rise   = ~fs_d & fs_s;

  always_comb begin
    active_n = active_q;
    full_n   = full_q;
    cnt_n    = cnt_q;
    shreg_n  = shreg_q;
    commit_n = 1'b0;
    cword_n  = cword_q;
    if (csn_s) begin
      active_n = 1'b0;
      full_n   = 1'b0;
    end else if (fs_fall) begin
      active_n = 1'b1;
      full_n   = 1'b0;
      cnt_n    = '0;
      shreg_n  = '0;
    end else if (active_q) begin
      if (fs_rise || (full_q && sclk_rise)) begin
        active_n = 1'b0;
        full_n   = 1'b0;
        if (cnt_q != '0) begin
          commit_n = 1'b1;
          cword_n  = shreg_q;
        end
      end else if (!full_q && sclk_fall) begin
        for (int i = 0; i < WORD_W; i++)
          if (cnt_q == CNT_W'(WORD_W - 1 - i)) shreg_n[i] = din_s;
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(WORD_W - 1)) full_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b1;
      fs_d     <= 1'b1;
      active_q <= 1'b0;
      full_q   <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      commit_q <= 1'b0;
      cword_q  <= '0;
    end else begin
      sclk_d   <= sclk_s;
      fs_d     <= fs_s;
      active_q <= active_n;
      full_q   <= full_n;
      cnt_q    <= cnt_n;
      shreg_q  <= shreg_n;
      commit_q <= commit_n;
      cword_q  <= cword_n;
    end
  end

  assign commit_o = commit_q;
  assign word_o   = cword_q;
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
  import sdac_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] dac_o,
  output logic [REF_W-1:0]  ref_o,
  output logic              fast_o,
  output logic              pwrdn_o,
  output logic              upd_o
);
  logic [DATA_W-1:0] dac_q, dac_n;
  logic [REF_W-1:0]  ref_q, ref_n;
  logic              fast_q, fast_n, pd_q, pd_n, upd_q, upd_n;
  sel_e              sel;

  assign sel = sel_e'({word_i[SEL_HI_BIT], word_i[SEL_LO_BIT]});

  always_comb begin
    dac_n  = dac_q;
    ref_n  = ref_q;
    fast_n = fast_q;
    pd_n   = pd_q;
    upd_n  = commit_i;
    if (commit_i) begin
      fast_n = word_i[SPD_BIT];
      pd_n   = word_i[PWR_BIT];
      case (sel)
        SEL_DAC: dac_n = word_i[PAY_MSB -: DATA_W];
        SEL_CTL: ref_n = word_i[REF_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q  <= '0;
      ref_q  <= '0;
      fast_q <= 1'b0;
      pd_q   <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      dac_q  <= dac_n;
      ref_q  <= ref_n;
      fast_q <= fast_n;
      pd_q   <= pd_n;
      upd_q  <= upd_n;
    end
  end

  assign dac_o   = dac_q;
  assign ref_o   = ref_q;
  assign fast_o  = fast_q;
  assign pwrdn_o = pd_q;
  assign upd_o   = upd_q;
endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx
  import sdac_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_i,
  input  logic              fs_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic              fast_o,
  output logic              pwrdn_o,
  output logic              upd_o
);
  localparam int NPIN = 4;

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [NPIN-1:0]   pins_s;
  logic              commit;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  sdac_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   ({csn_i, fs_i, sclk_i, din_i}),
    .q_o   (pins_s)
  );

  sdac_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .csn_s    (pins_s[3]),
    .fs_s     (pins_s[2]),
    .sclk_s   (pins_s[1]),
    .din_s    (pins_s[0]),
    .commit_o (commit),
    .word_o   (word)
  );

  sdac_latch #(.DATA_W(DATA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .commit_i (commit),
    .word_i   (word),
    .dac_o    (dac_code_o),
    .ref_o    (ref_sel_o),
    .fast_o   (fast_o),
    .pwrdn_o  (pwrdn_o),
    .upd_o    (upd_o)
  );
endmodule

// File: rtl/sdac_cmd_rx_chk.sv
module sdac_cmd_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn_i,
  input logic              commit_i,
  input logic [DATA_W-1:0] dac_code_o,
  input logic [1:0]        ref_sel_o,
  input logic              fast_o,
  input logic              pwrdn_o,
  input logic              upd_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_zero: assert (dac_code_o == '0 && ref_sel_o == '0 && !fast_o && !pwrdn_o && !upd_o);
    end
  end

  a_r9_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  a_r3_commit_to_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> upd_o);

  a_r5_code_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code_o) |-> upd_o);

  a_r6_ref_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_sel_o) |-> upd_o);

  a_r8_modes_move_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({fast_o, pwrdn_o}) |-> upd_o);

  a_r1_deselect_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3) && $past(csn_i, 4)) |-> !commit_i);
endmodule

bind sdac_cmd_rx sdac_cmd_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csn_i      (csn_i),
  .commit_i   (u_frame.commit_o),
  .dac_code_o (dac_code_o),
  .ref_sel_o  (ref_sel_o),
  .fast_o     (fast_o),
  .pwrdn_o    (pwrdn_o),
  .upd_o      (upd_o)
);

// File: tb/sdac_cmd_rx_tb.sv
module sdac_cmd_rx_tb;
  localparam int HALF = 6;

  typedef struct packed {
    logic [7:0] dac;
    logic [1:0] rf;
    logic       fast;
    logic       pd;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       csn = 1'b1, fs = 1'b1, sclk = 1'b1, din = 1'b0;
  logic [7:0] dac_code_o;
  logic [1:0] ref_sel_o;
  logic       fast_o, pwrdn_o, upd_o;

  int   checks = 0, errors = 0;
  bit   done = 0;
  logic prev_upd = 1'b0;
  exp_t model = '0;
  exp_t q[$];

  always #5 clk = ~clk;

  sdac_cmd_rx u_dut (
    .clk(clk), .rst_n(rst_n), .csn_i(csn), .fs_i(fs), .sclk_i(sclk), .din_i(din),
    .dac_code_o(dac_code_o), .ref_sel_o(ref_sel_o), .fast_o(fast_o),
    .pwrdn_o(pwrdn_o), .upd_o(upd_o)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: each strobe pops one expected item (R9, R3)
  always @(negedge clk) begin
    if (rst_n && upd_o) begin
      exp_t got, e;
      got = '{dac: dac_code_o, rf: ref_sel_o, fast: fast_o, pd: pwrdn_o};
      checks++;
      if (prev_upd) begin
        errors++;
        $display("FAIL R9 strobe wider than one cycle: got 1 expected 0");
      end else if (q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected strobe: got outputs %h expected no strobe", got);
      end else begin
        e = q.pop_front();
        if (got !== e) begin
          errors++;
          $display("FAIL R3 committed outputs: got %h expected %h", got, e);
        end
      end
    end
    prev_upd = upd_o;
  end

  task automatic check_state(input string tag);
    exp_t got;
    got = '{dac: dac_code_o, rf: ref_sel_o, fast: fast_o, pd: pwrdn_o};
    checks++;
    if (got !== model || q.size() != 0) begin
      errors++;
      $display("FAIL %s: got %h pending %0d expected %h pending 0", tag, got, q.size(), model);
    end
  endtask

  // Driver: sends nbits of w; a frame with fewer than 16 bits ends on a rising frame-sync
  task automatic send(input logic [15:0] w, input int nbits, input logic sel_n, input string tag);
    logic [15:0] wf;
    wf = w;
    for (int i = 0; i < 16; i++) if (i < 16 - nbits) wf[i] = 1'b0;
    if (!sel_n && nbits > 0) begin
      model.fast = wf[14];
      model.pd   = wf[13];
      if ({wf[15], wf[12]} == 2'b00) model.dac = wf[11:4];
      if ({wf[15], wf[12]} == 2'b11) model.rf  = wf[1:0];
      q.push_back(model);
    end
    csn = sel_n; wait_cyc(HALF);
    fs = 1'b0;   wait_cyc(HALF);
    for (int i = 0; i < nbits; i++) begin
      din = w[15-i]; wait_cyc(HALF);
      sclk = 1'b0;   wait_cyc(HALF);
      sclk = 1'b1;
    end
    wait_cyc(HALF);
    fs = 1'b1;
    wait_cyc(20);
    check_state(tag);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    wait_cyc(5);
    check_state("R10 reset state");
    rst_n = 1'b1;
    wait_cyc(5);
    check_state("R10 after release");
    send(16'h4A50, 16, 1'b0, "R5 R2 code write A5 fast");
    send(16'hD002, 16, 1'b0, "R6 control ref=2");
    send(16'hBFFD, 16, 1'b0, "R6 dont-care payload ref=1 pd");
    send(16'h73C0, 16, 1'b0, "R7 reserved 01");
    send(16'h8110, 16, 1'b0, "R7 reserved 10 R8 modes");
    send(16'h4FF0, 16, 1'b1, "R1 deselected word ignored");
    send(16'h4FF0, 8,  1'b0, "R4 early commit 8 bits");
    send(16'h0FFF, 12, 1'b0, "R4 early commit 12 bits");
    send(16'hFFFF, 1,  1'b0, "R4 single bit reserved select");
    send(16'h4AB0, 0,  1'b0, "R11 empty frame");
    // R1: deselect halfway through a frame abandons it
    csn = 1'b0; wait_cyc(HALF);
    fs = 1'b0;  wait_cyc(HALF);
    for (int i = 0; i < 8; i++) begin
      din = 1'b1; wait_cyc(HALF);
      sclk = 1'b0; wait_cyc(HALF);
      sclk = 1'b1;
    end
    csn = 1'b1; wait_cyc(HALF);
    fs = 1'b1;  wait_cyc(20);
    check_state("R1 mid-frame deselect");
    send(16'h0000, 16, 1'b0, "R5 code zero slow");
    send(16'h4FF0, 16, 1'b0, "R5 code full scale");
    send(16'h6120, 16, 1'b0, "R8 fast and power-down");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule